// File: doc/BRIEF.md
# Two-Dimensional DMA Address Generator

This block produces the byte addresses of a one- or two-dimensional DMA transfer, one address per element. Software supplies a start address, a row length (inner count), a row total (outer count), two signed strides and an element size, then pulses `start`. The generator sends each element's address on a valid/ready stream. Within a row the address moves by the inner stride. On the last element of a row it moves by the outer stride instead, and the inner count reloads. The outer stride may be smaller than the inner stride, or negative, so data stored interleaved can be read one channel at a time.

An address is offered while `out_valid` is high and is consumed on a cycle where `out_ready` is also high. While `out_ready` is low, the address and both flags hold still and nothing advances. A consumer may hold `out_ready` low for as long as it needs. The generator does not wait for `out_ready` before raising `out_valid`.

Two completion modes exist. In stop mode the generator halts after the final element and raises `done`. In autobuffer mode it reloads the latched start parameters and carries on. In that mode it raises `irq` for one cycle after each completed buffer, or after each completed row when that option is selected. The current address and the remaining counts are visible on outputs throughout a transfer.

Top module: `dma2d_addr_gen`

## Requirements
- R1: After reset, `out_valid`, `busy`, `done` and `irq` are all low.
- R2: A `start` pulse while idle latches every configuration input. The first address offered is the start address. A `start` pulse while busy is ignored, and the running sequence is unchanged.
- R3: After a consumed element that is not a row end, the next address is the current address plus the inner stride times the element size. Element size codes are: 0 = 1 byte, 1 = 2 bytes, 2 = 4 bytes.
- R4: `out_row_end` is high on the last element of each row. After that element is consumed, the next address is the current address plus the outer stride times the element size, the inner count reloads, and the outer count drops by one.
- R5: A count value of 0 means 65536 elements.
- R6: `out_last` is high on the final element of the transfer. In stop mode, once that element is consumed, `busy` and `out_valid` fall and `done` rises on the next cycle. `done` stays high until the next accepted `start`.
- R7: While `out_valid` is high and `out_ready` is low, `out_addr`, `out_row_end` and `out_last` hold and `out_valid` stays high.
- R8: With `cfg_two_dim` low, the outer count input is ignored and treated as 1. The transfer is a single row, and its last element carries both `out_row_end` and `out_last`.
- R9: In autobuffer mode, once the final element is consumed, the generator reloads the start address and counts. It stays busy, and the next address offered is the start address.
- R10: In autobuffer mode, `irq` is a one-cycle pulse in the cycle after the consumed element ends a buffer. When `cfg_irq_per_row` is high, the pulse comes after each consumed element that ends a row.
- R11: The strides are signed 16-bit values. A negative outer stride, or one smaller than the inner stride, walks interleaved data channel by channel.
- R12: `inner_left` shows the elements left in the current row, counting the one offered. `outer_left` shows the rows left, counting the current one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin a transfer when idle |
| cfg_start_addr | input | AW | First byte address |
| cfg_inner_cnt | input | CW | Elements per row, 0 means 65536 |
| cfg_outer_cnt | input | CW | Rows per buffer, 0 means 65536 |
| cfg_inner_stride | input | SW | Signed step within a row, in elements |
| cfg_outer_stride | input | SW | Signed step at a row end, in elements |
| cfg_elem_size | input | 2 | 0 = 1 byte, 1 = 2 bytes, 2 = 4 bytes |
| cfg_two_dim | input | 1 | 1 = 2D, 0 = 1D |
| cfg_autobuf | input | 1 | 1 = reload and continue at the end, 0 = stop |
| cfg_irq_per_row | input | 1 | Autobuffer interrupt on every row instead of every buffer |
| out_valid | output | 1 | Address offered |
| out_ready | input | 1 | Consumer accepts the address |
| out_addr | output | AW | Current element address |
| out_row_end | output | 1 | Offered element ends a row |
| out_last | output | 1 | Offered element ends the transfer |
| busy | output | 1 | Transfer in progress |
| done | output | 1 | Stop-mode transfer finished |
| irq | output | 1 | Autobuffer interrupt pulse |
| inner_left | output | CW+1 | Elements left in the current row |
| outer_left | output | CW+1 | Rows left in the buffer |

## Verification
The bench runs a de-interleaving walk with a negative outer stride while `out_ready` stalls. A design that applied the inner stride at the row end, or moved on during a stall, would emit wrong or skipped addresses. A 1D run sets the outer count to 5, and a design that used that count anyway would emit extra rows. A 65536-element row checks the zero-count encoding, and a generator that read zero literally would finish at once or wrap. Autobuffer runs count the `irq` pulses per row and per buffer and check that the second buffer starts again at the start address. A stray `start` pulse mid-transfer must leave the sequence unchanged.

// File: rtl/dma2d_pkg.sv
package dma2d_pkg;
  typedef enum logic [1:0] {
    ESZ_BYTE = 2'b00,
    ESZ_HALF = 2'b01,
    ESZ_WORD = 2'b10
  } esz_e;

  typedef enum logic {
    ST_IDLE = 1'b0,
    ST_RUN  = 1'b1
  } gen_state_e;

  typedef enum logic [2:0] {
    AS_HOLD,
    AS_LOAD_NEW,
    AS_RELOAD,
    AS_INNER,
    AS_OUTER
  } addr_sel_e;
endpackage

// File: rtl/dma2d_stride_scale.sv
module dma2d_stride_scale
  import dma2d_pkg::*;
#(
  parameter int AW = 32,
  parameter int SW = 16
) (
  input  logic [SW-1:0] stride,
  input  logic [1:0]    esz,
  output logic [AW-1:0] step
);
  logic [AW-1:0] ext;

  always_comb begin
    ext = {{(AW-SW){stride[SW-1]}}, stride};
    case (esz_e'(esz))
      ESZ_HALF: step = ext << 1;
      ESZ_WORD: step = ext << 2;
      default:  step = ext;
    endcase
  end
endmodule

// File: rtl/dma2d_dim_counter.sv
module dma2d_dim_counter #(
  parameter int CW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic          dec,
  input  logic [CW-1:0] load_val,
  output logic [CW:0]   count,
  output logic          at_one
);
  localparam logic [CW:0] FULL = {1'b1, {CW{1'b0}}};
  localparam logic [CW:0] ONE  = {{CW{1'b0}}, 1'b1};

  always_ff @(posedge clk) begin
    if (!rst_n)        count <= '0;
    else if (load)     count <= (load_val == '0) ? FULL : {1'b0, load_val};
    else if (dec)      count <= count - ONE;
  end

  assign at_one = (count == ONE);
endmodule

// File: rtl/dma2d_seq_ctrl.sv
module dma2d_seq_ctrl
  import dma2d_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      start,
  input  logic      hs,
  input  logic      inner_last,
  input  logic      outer_last,
  input  logic      autobuf,
  input  logic      irq_per_row,
  output logic      busy,
  output logic      done,
  output logic      irq,
  output logic      accept_start,
  output logic      inner_load,
  output logic      inner_dec,
  output logic      outer_load,
  output logic      outer_dec,
  output addr_sel_e addr_sel
);
  gen_state_e state;
  logic row_done, buf_done;

  assign accept_start = start && (state == ST_IDLE);
  assign row_done     = hs && inner_last;
  assign buf_done     = row_done && outer_last;
  assign inner_load   = accept_start || row_done;
  assign inner_dec    = hs && !inner_last;
  assign outer_load   = accept_start || (buf_done && autobuf);
  assign outer_dec    = row_done && !outer_last;
  assign busy         = (state == ST_RUN);

  always_comb begin
    if (accept_start)                  addr_sel = AS_LOAD_NEW;
    else if (buf_done && autobuf)      addr_sel = AS_RELOAD;
    else if (row_done && !outer_last)  addr_sel = AS_OUTER;
    else if (inner_dec)                addr_sel = AS_INNER;
    else                               addr_sel = AS_HOLD;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state <= ST_IDLE;
      done  <= 1'b0;
      irq   <= 1'b0;
    end else begin
      irq <= autobuf && (irq_per_row ? row_done : buf_done);
      if (accept_start) begin
        state <= ST_RUN;
        done  <= 1'b0;
      end else if (buf_done && !autobuf) begin
        state <= ST_IDLE;
        done  <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/dma2d_addr_gen.sv
module dma2d_addr_gen
  import dma2d_pkg::*;
#(
  parameter int AW = 32,
  parameter int CW = 16,
  parameter int SW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic [AW-1:0] cfg_start_addr,
  input  logic [CW-1:0] cfg_inner_cnt,
  input  logic [CW-1:0] cfg_outer_cnt,
  input  logic [SW-1:0] cfg_inner_stride,
  input  logic [SW-1:0] cfg_outer_stride,
  input  logic [1:0]    cfg_elem_size,
  input  logic          cfg_two_dim,
  input  logic          cfg_autobuf,
  input  logic          cfg_irq_per_row,
  output logic          out_valid,
  input  logic          out_ready,
  output logic [AW-1:0] out_addr,
  output logic          out_row_end,
  output logic          out_last,
  output logic          busy,
  output logic          done,
  output logic          irq,
  output logic [CW:0]   inner_left,
  output logic [CW:0]   outer_left
);
  localparam logic [CW-1:0] ONE_ROW = {{(CW-1){1'b0}}, 1'b1};

  logic [AW-1:0] lat_start;
  logic [CW-1:0] lat_icnt, lat_ocnt;
  logic [SW-1:0] lat_istr, lat_ostr;
  logic [1:0]    lat_esz;
  logic          lat_auto, lat_rowirq;

  logic          accept_start, hs;
  logic          inner_load, inner_dec, outer_load, outer_dec;
  logic          inner_last, outer_last;
  addr_sel_e     addr_sel;
  logic [AW-1:0] istep, ostep;
  logic [CW-1:0] ocnt_eff;

  assign ocnt_eff = cfg_two_dim ? cfg_outer_cnt : ONE_ROW;
  assign hs       = out_valid && out_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      lat_start  <= '0;
      lat_icnt   <= '0;
      lat_ocnt   <= '0;
      lat_istr   <= '0;
      lat_ostr   <= '0;
      lat_esz    <= '0;
      lat_auto   <= 1'b0;
      lat_rowirq <= 1'b0;
    end else if (accept_start) begin
      lat_start  <= cfg_start_addr;
      lat_icnt   <= cfg_inner_cnt;
      lat_ocnt   <= ocnt_eff;
      lat_istr   <= cfg_inner_stride;
      lat_ostr   <= cfg_outer_stride;
      lat_esz    <= cfg_elem_size;
      lat_auto   <= cfg_autobuf;
      lat_rowirq <= cfg_irq_per_row;
    end
  end

  dma2d_stride_scale #(.AW(AW), .SW(SW)) u_istep (
    .stride(lat_istr), .esz(lat_esz), .step(istep));
  dma2d_stride_scale #(.AW(AW), .SW(SW)) u_ostep (
    .stride(lat_ostr), .esz(lat_esz), .step(ostep));

  dma2d_dim_counter #(.CW(CW)) u_inner (
    .clk(clk), .rst_n(rst_n), .load(inner_load), .dec(inner_dec),
    .load_val(accept_start ? cfg_inner_cnt : lat_icnt),
    .count(inner_left), .at_one(inner_last));

  dma2d_dim_counter #(.CW(CW)) u_outer (
    .clk(clk), .rst_n(rst_n), .load(outer_load), .dec(outer_dec),
    .load_val(accept_start ? ocnt_eff : lat_ocnt),
    .count(outer_left), .at_one(outer_last));

  dma2d_seq_ctrl u_ctrl (
    .clk(clk), .rst_n(rst_n), .start(start), .hs(hs),
    .inner_last(inner_last), .outer_last(outer_last),
    .autobuf(lat_auto), .irq_per_row(lat_rowirq),
    .busy(busy), .done(done), .irq(irq), .accept_start(accept_start),
    .inner_load(inner_load), .inner_dec(inner_dec),
    .outer_load(outer_load), .outer_dec(outer_dec), .addr_sel(addr_sel));

  always_ff @(posedge clk) begin
    if (!rst_n) out_addr <= '0;
    else begin
      case (addr_sel)
        AS_LOAD_NEW: out_addr <= cfg_start_addr;
        AS_RELOAD:   out_addr <= lat_start;
        AS_INNER:    out_addr <= out_addr + istep;
        AS_OUTER:    out_addr <= out_addr + ostep;
        default:     out_addr <= out_addr;
      endcase
    end
  end

  assign out_valid   = busy;
  assign out_row_end = busy && inner_last;
  assign out_last    = busy && inner_last && outer_last;
endmodule

// File: rtl/dma2d_addr_gen_chk.sv
module dma2d_addr_gen_chk #(
  parameter int AW = 32,
  parameter int CW = 16
) (
  input logic          clk,
  input logic          rst_n,
  input logic          out_valid,
  input logic          out_ready,
  input logic [AW-1:0] out_addr,
  input logic          out_row_end,
  input logic          out_last,
  input logic          busy,
  input logic          done,
  input logic          irq,
  input logic [CW:0]   inner_left,
  input logic          cfg_autobuf
);
  localparam logic [CW:0] ONE = {{CW{1'b0}}, 1'b1};

  p_idle_quiet_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !out_valid);

  p_hold_stall_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_addr)
      && $stable(out_row_end) && $stable(out_last)));

  p_row_end_count_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_row_end) |-> (inner_left == ONE));

  p_inner_dec_r12: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_ready && !out_row_end) |=> (inner_left == $past(inner_left) - ONE));

  p_stop_done_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_ready && out_last && !cfg_autobuf) |=> (done && !busy));

  p_auto_reload_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_ready && out_last && cfg_autobuf) |=> (busy && out_valid));

  p_irq_cause_r10: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> $past(out_valid && out_ready && out_row_end));
endmodule

bind dma2d_addr_gen dma2d_addr_gen_chk #(.AW(AW), .CW(CW)) u_chk (
  .clk(clk), .rst_n(rst_n), .out_valid(out_valid), .out_ready(out_ready),
  .out_addr(out_addr), .out_row_end(out_row_end), .out_last(out_last),
  .busy(busy), .done(done), .irq(irq), .inner_left(inner_left),
  .cfg_autobuf(cfg_autobuf));

// File: tb/dma2d_addr_gen_tb_top.sv
`timescale 1ns/1ps
module dma2d_addr_gen_tb_top;
  localparam int AW = 32;
  localparam int CW = 16;
  localparam int SW = 16;

  typedef struct {
    logic [AW-1:0] a;
    logic          re;
    logic          la;
    logic [CW:0]   il;
    logic [CW:0]   ol;
    string         req;
  } exp_t;

  logic clk = 0, rst_n = 0, start = 0;
  logic [AW-1:0] cfg_start_addr = '0;
  logic [CW-1:0] cfg_inner_cnt = '0, cfg_outer_cnt = '0;
  logic [SW-1:0] cfg_inner_stride = '0, cfg_outer_stride = '0;
  logic [1:0]    cfg_elem_size = '0;
  logic cfg_two_dim = 0, cfg_autobuf = 0, cfg_irq_per_row = 0;
  logic out_valid, out_ready = 0, out_row_end, out_last, busy, done, irq;
  logic [AW-1:0] out_addr;
  logic [CW:0]   inner_left, outer_left;

  exp_t q[$];
  int n_tests = 0, n_fail = 0, irq_seen = 0, stall_mode = 0, cyc = 0;
  bit hold_chk = 0;
  logic [AW-1:0] held_addr;

  always #2.5 clk = ~clk;

  dma2d_addr_gen #(.AW(AW), .CW(CW), .SW(SW)) dut_i (.*);

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  // monitor: decide ready for the coming edge, then score the handshake
  always @(negedge clk) begin
    cyc++;
    if (!rst_n) begin
      out_ready = 0;
      hold_chk = 0;
    end else begin
      if (irq) irq_seen++;
      if (hold_chk) begin
        chk(out_valid && out_addr == held_addr, "R7", "stalled address", out_addr, held_addr);
        hold_chk = 0;
      end
      out_ready = (q.size() > 0) && (stall_mode == 0 || (cyc % 3) != 0);
      if (out_valid && out_ready) begin
        exp_t e;
        e = q.pop_front();
        chk(out_addr == e.a, e.req, "address", out_addr, e.a);
        chk(out_row_end == e.re && out_last == e.la, e.req, "row_end/last",
            {out_row_end, out_last}, {e.re, e.la});
        chk(inner_left == e.il && outer_left == e.ol, "R12", "remaining counts",
            {inner_left, outer_left}, {e.il, e.ol});
      end else if (out_valid) begin
        hold_chk = 1;
        held_addr = out_addr;
      end
    end
  end

  task automatic push_seq(input logic [AW-1:0] sa, input int ic, input int oc,
                          input int is, input int os, input int eb, input int nbuf,
                          input string req);
    for (int b = 0; b < nbuf; b++) begin
      logic [AW-1:0] a;
      a = sa;
      for (int r = 0; r < oc; r++) begin
        for (int i = 0; i < ic; i++) begin
          exp_t e;
          e.a = a; e.re = (i == ic - 1); e.la = (i == ic - 1) && (r == oc - 1);
          e.il = (CW+1)'(ic - i); e.ol = (CW+1)'(oc - r);
          e.req = (b > 0 && r == 0 && i == 0) ? "R9" : req;
          q.push_back(e);
          a = a + AW'((i == ic - 1 ? os : is) * eb);
        end
      end
    end
  endtask

  task automatic do_reset();
    rst_n = 0; start = 0;
    q.delete();
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk(!out_valid && !busy && !done && !irq, "R1", "reset outputs",
        {out_valid, busy, done, irq}, 0);
  endtask

  task automatic pulse_start();
    @(negedge clk) start = 1;
    @(negedge clk) start = 0;
  endtask

  task automatic drain();
    int t = 0;
    while (q.size() != 0 && t < 150000) begin
      @(negedge clk);
      t++;
    end
    chk(q.size() == 0, "R3", "all elements emitted", q.size(), 0);
    repeat (3) @(negedge clk);
  endtask

  task automatic setup(input logic [AW-1:0] sa, input int ic, input int oc,
                       input int is, input int os, input logic [1:0] esz,
                       input bit two_d, input bit ab, input bit per_row);
    cfg_start_addr = sa; cfg_inner_cnt = CW'(ic); cfg_outer_cnt = CW'(oc);
    cfg_inner_stride = SW'(is); cfg_outer_stride = SW'(os);
    cfg_elem_size = esz; cfg_two_dim = two_d; cfg_autobuf = ab; cfg_irq_per_row = per_row;
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    n_tests++; n_fail++;
    $display("FAIL watchdog: actual %0d expected 0 remaining", q.size());
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    do_reset();

    // R3 R4 R6 R12: 4 x 3 grid of words, stop mode
    stall_mode = 0;
    setup(32'h1000, 4, 3, 1, 5, 2'b10, 1, 0, 0);
    push_seq(32'h1000, 4, 3, 1, 5, 4, 1, "R3/R4");
    pulse_start();
    chk(out_valid && out_addr == 32'h1000, "R2", "first address", out_addr, 32'h1000);
    chk(inner_left == 4 && outer_left == 3, "R12", "start counts", {inner_left, outer_left}, {17'd4, 17'd3});
    drain();
    chk(!busy && !out_valid && done, "R6", "stop completion", {busy, out_valid, done}, 3'b001);

    // R11 R7 R2: de-interleave 3 channels of 4 halfwords, stalls, stray start
    do_reset();
    stall_mode = 1;
    setup(32'h2000, 4, 3, 3, -8, 2'b01, 1, 0, 0);
    push_seq(32'h2000, 4, 3, 3, -8, 2, 1, "R11");
    pulse_start();
    repeat (3) @(negedge clk);
    cfg_start_addr = 32'h9000; cfg_inner_cnt = 2;
    pulse_start();
    cfg_start_addr = 32'h2000; cfg_inner_cnt = 4;
    drain();
    chk(done && !busy, "R2", "stray start left sequence intact", {done, busy}, 2'b10);

    // R8: 1D, outer count ignored, negative byte stride
    do_reset();
    stall_mode = 0;
    setup(32'h200, 6, 5, -1, 7, 2'b00, 0, 0, 0);
    push_seq(32'h200, 6, 1, -1, 7, 1, 1, "R8");
    pulse_start();
    chk(outer_left == 1, "R8", "1D outer count", outer_left, 1);
    drain();
    chk(done && !busy, "R8", "1D completion", {done, busy}, 2'b10);

    // R9 R10: autobuffer, interrupt per buffer
    do_reset();
    irq_seen = 0;
    setup(32'h3000, 3, 2, 2, -3, 2'b10, 1, 1, 0);
    push_seq(32'h3000, 3, 2, 2, -3, 4, 2, "R3/R4");
    pulse_start();
    drain();
    chk(busy && out_valid && !done, "R9", "autobuffer keeps running", {busy, out_valid, done}, 3'b110);
    chk(out_addr == 32'h3000, "R9", "third buffer start", out_addr, 32'h3000);
    chk(irq_seen == 2, "R10", "per-buffer irq count", irq_seen, 2);

    // R10: autobuffer, interrupt per row
    do_reset();
    irq_seen = 0;
    stall_mode = 1;
    setup(32'h4000, 2, 3, 1, 1, 2'b01, 1, 1, 1);
    push_seq(32'h4000, 2, 3, 1, 1, 2, 2, "R10");
    pulse_start();
    drain();
    chk(irq_seen == 6, "R10", "per-row irq count", irq_seen, 6);

    // R5: inner count 0 means 65536
    do_reset();
    stall_mode = 0;
    setup(32'h0, 0, 0, 1, 1, 2'b00, 0, 0, 0);
    push_seq(32'h0, 65536, 1, 1, 1, 1, 1, "R5");
    pulse_start();
    chk(inner_left == 17'h10000, "R5", "zero count load", inner_left, 17'h10000);
    drain();
    chk(done && !busy, "R5", "65536-element completion", {done, busy}, 2'b10);

    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule